// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Detection

This block is the digital serial side of a telephony voice codec. In each frame it sends one 8-bit companded sample on a transmit data line and receives one on a receive data line. The transmit side and the receive side each have a bit clock and a frame-sync line. A fast system clock samples all of these pins. Each pin passes through a two-flop synchronizer before its edges are detected, so both bit clocks must run at least eight times slower than the system clock.

The block measures how long the transmit frame-sync pulse stays high. From that width it decides whether short pulses (one bit period) or long pulses (three or more bit periods) are in use. The transmit line is modelled as a data bit plus an output enable. The enable is asserted only while a sample is on the line. Received bits are shifted MSB first into a parallel word, which is published with a one-cycle strobe. A strap input makes the receive side take its bit clock from the transmit bit clock.

Four state machines do the work.

The mode tracker has two states:
- `FS_SHORT`: the reset state.
- `FS_LONG`.
- It changes state only when the transmit sync falls.

The transmitter has four states:
- `TX_IDLE`.
- `TX_ARMED`: sync has been seen and the block waits for a bit-clock rise.
- `TX_SHIFT`: the output is enabled and bits are being sent.
- `TX_HOLD`: all bits are out and the block waits for a long sync to end.

Its transitions are:
- IDLE→ARMED: short sync is high at a falling edge, or long sync rises while the bit clock is low.
- IDLE→SHIFT: long sync rises while the bit clock is high.
- ARMED→SHIFT: the bit clock rises.
- SHIFT→IDLE or SHIFT→HOLD: the falling edge after the eighth rise.
- HOLD→IDLE: sync goes low.

The receiver has three states:
- `RX_IDLE`.
- `RX_SHIFT`: eight bits are captured on falling edges.
- `RX_PUBLISH`: a single cycle that carries the strobe.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `tx_oe` and `tx_dout` are 0, `rx_valid` is 0 and `frame_long` is 0, which means short-frame mode.
- R2: In short mode, if `tx_fsync` is high at a falling edge of `tx_bclk`, then at the next rising edge `tx_oe` goes high and `tx_dout` carries bit 7 (the sign bit) of the word being sent.
- R3: In short mode, bits 6 down to 0 follow on the next seven rising edges of `tx_bclk`. The falling edge after that eighth rise drops `tx_oe` to 0.
- R4: In short mode, if `rx_fsync` is high at a falling edge of the receive bit clock, the next eight falling edges capture `rx_din` MSB first. The word then appears on `rx_word` with `rx_valid`.
- R5: Only `tx_fsync` is measured, and the decision is taken when it falls. A pulse that spans three or more `tx_bclk` falling edges sets `frame_long` to 1. A pulse that spans exactly one sets it to 0. The width of `rx_fsync` has no effect on the mode.
- R6: A `tx_fsync` pulse that spans exactly two falling edges leaves `frame_long` unchanged, in either mode.
- R7: In long mode, `tx_oe` rises at the later of two events: the rise of `tx_fsync`, or a rise of `tx_bclk`. If the bit clock is already high when sync rises, the enable follows the sync edge. Bit 7 is driven first, and each of the next seven `tx_bclk` rises moves on one bit.
- R8: In long mode, `tx_oe` falls at the later of two events: the `tx_bclk` falling edge after the eighth rise, or `tx_fsync` going low. While it waits for sync, the output keeps driving bit 0.
- R9: In long mode, a rise of `rx_fsync` starts a capture on the next eight falling edges of the receive bit clock, MSB first.
- R10: With `sync_mode` = 1, the receive side clocks on `tx_bclk` and ignores `rx_bclk`. With `sync_mode` = 0, it uses `rx_bclk`, and no word is received while `rx_bclk` is idle.
- R11: A `tx_load` pulse stores `tx_word` in a holding register. Each frame sends the value held when that frame starts. A load during a frame takes effect from the next frame.
- R12: `rx_valid` is high for exactly one system clock per received frame. `rx_word` holds its value until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x either bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1: receive side uses the transmit bit clock |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync; its width selects the mode |
| tx_word | input | 8 | Sample to send |
| tx_load | input | 1 | Stores `tx_word` into the holding register |
| tx_dout | output | 1 | Transmit data bit (0 when not enabled) |
| tx_oe | output | 1 | Output enable of the tri-state transmit driver |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Receive data bit |
| rx_word | output | 8 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |
| frame_long | output | 1 | 1 when long frame-sync mode is detected |

## Verification
The bench focuses on three corner cases.
- Frames during which the mode switches, and two-period sync pulses. A wrong mode tracker would flip modes on the wrong width or would react to the receive sync.
- Long sync rising while the bit clock is already high, and long sync rising while it is low. A design that always waits for a clock rise would drop or delay the sign bit.
- Long sync held past the eighth bit. A design that ignores the "later event" rule would release the line early.

It also checks the following:
- A load issued in the middle of a frame. A design that did not freeze the word at frame start would corrupt the data on the line.
- A stuck receive clock with and without `sync_mode`. A broken clock select would either miss the word or capture from a dead clock.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    typedef enum logic {
        FS_SHORT,
        FS_LONG
    } fs_mode_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARMED,
        TX_SHIFT,
        TX_HOLD
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_PUBLISH
    } rx_state_e;

endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
    parameter int N      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] level
);
    logic [N-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pins;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign level = stage_q[STAGES-1];
endmodule

// File: rtl/pcm_fs_detect.sv
module pcm_fs_detect #(
    parameter int LONG_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_level,
    input  logic fs_rise,
    input  logic fs_fall,
    input  logic bclk_fall,
    output logic mode_long
);
    import pcm_pkg::*;

    localparam int CW = $clog2(LONG_MIN + 1);
    localparam logic [CW-1:0] LIM = CW'(LONG_MIN);
    localparam logic [CW-1:0] ONE = CW'(1);

    fs_mode_e      mode_q, mode_d;
    logic [CW-1:0] width_q;

    // Mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= FS_SHORT;
        else        mode_q <= mode_d;
    end

    // Decision at the end of each transmit sync pulse
    always_comb begin
        mode_d = mode_q;
        if (fs_fall) begin
            unique case (mode_q)
                FS_SHORT: if (width_q >= LIM) mode_d = FS_LONG;
                FS_LONG:  if (width_q == ONE) mode_d = FS_SHORT;
                default:  mode_d = FS_SHORT;
            endcase
        end
    end

    // Counts bit-clock falls seen while sync is high, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
        end else if (fs_rise) begin
            width_q <= bclk_fall ? ONE : '0;
        end else if (fs_level && bclk_fall && width_q != LIM) begin
            width_q <= width_q + 1'b1;
        end
    end

    assign mode_long = (mode_q == FS_LONG);
endmodule

// File: rtl/pcm_tx_fsm.sv
module pcm_tx_fsm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_long,
    input  logic         bclk_level,
    input  logic         bclk_rise,
    input  logic         bclk_fall,
    input  logic         fs_level,
    input  logic         fs_rise,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         dout,
    output logic         oe
);
    import pcm_pkg::*;

    localparam int BCW = $clog2(W + 1);
    localparam logic [BCW-1:0] LAST = BCW'(W);
    localparam logic [BCW-1:0] FIRST = BCW'(1);

    tx_state_e      st_q, st_d;
    logic [W-1:0]   hold_q, shift_q;
    logic [BCW-1:0] sent_q;
    logic           start_now, arm;

    // Long mode: sync rising while the clock is high starts at once.
    // Otherwise wait in ARMED for the next clock rise.
    always_comb begin
        start_now = mode_long && fs_rise && bclk_level;
        arm       = mode_long ? (fs_rise && !bclk_level)
                              : (fs_level && bclk_fall);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE: begin
                if (start_now)  st_d = TX_SHIFT;
                else if (arm)   st_d = TX_ARMED;
            end
            TX_ARMED: if (bclk_rise) st_d = TX_SHIFT;
            TX_SHIFT: begin
                if (sent_q == LAST && bclk_fall)
                    st_d = (mode_long && fs_level) ? TX_HOLD : TX_IDLE;
            end
            TX_HOLD:  if (!fs_level) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    // Holding register, shifter and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shift_q <= '0;
            sent_q  <= '0;
        end else begin
            if (load) hold_q <= word;
            if (st_q == TX_IDLE && (start_now || arm)) shift_q <= hold_q;
            if (st_d == TX_SHIFT && st_q != TX_SHIFT) begin
                sent_q <= FIRST;
            end else if (st_q == TX_SHIFT && bclk_rise && sent_q != LAST) begin
                shift_q <= {shift_q[W-2:0], 1'b0};
                sent_q  <= sent_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        oe   = (st_q == TX_SHIFT) || (st_q == TX_HOLD);
        dout = oe & shift_q[W-1];
    end
endmodule

// File: rtl/pcm_rx_fsm.sv
module pcm_rx_fsm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_long,
    input  logic         bclk_fall,
    input  logic         fs_level,
    input  logic         fs_rise,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         valid
);
    import pcm_pkg::*;

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    rx_state_e     st_q, st_d;
    logic [W-1:0]  shift_q, word_q;
    logic [CW-1:0] got_q;
    logic          start;

    always_comb start = mode_long ? fs_rise : (fs_level && bclk_fall);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:    if (start) st_d = RX_SHIFT;
            RX_SHIFT:   if (bclk_fall && got_q == LAST) st_d = RX_PUBLISH;
            RX_PUBLISH: st_d = RX_IDLE;
            default:    st_d = RX_IDLE;
        endcase
    end

    // Capture path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            word_q  <= '0;
            got_q   <= '0;
        end else begin
            if (st_q == RX_IDLE && start) got_q <= '0;
            if (st_q == RX_SHIFT && bclk_fall) begin
                shift_q <= {shift_q[W-2:0], din};
                got_q   <= got_q + 1'b1;
                if (got_q == LAST) word_q <= {shift_q[W-2:0], din};
            end
        end
    end

    // Outputs
    always_comb begin
        valid = (st_q == RX_PUBLISH);
        word  = word_q;
    end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LONG_MIN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              tx_bclk,
    input  logic              tx_fsync,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_load,
    output logic              tx_dout,
    output logic              tx_oe,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_din,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              frame_long
);
    localparam int I_TXB = 0;
    localparam int I_TXF = 1;
    localparam int I_RXB = 2;
    localparam int I_RXF = 3;
    localparam int I_DIN = 4;
    localparam int I_SM  = 5;
    localparam int NPIN  = 6;
    localparam int NEDGE = 4;

    logic [NPIN-1:0]  raw, lvl;
    logic [NEDGE-1:0] prev_q;
    logic tx_bclk_rise, tx_bclk_fall, tx_fs_rise, tx_fs_fall;
    logic rx_bclk_fall, rx_fs_rise, rx_clk_fall;

    assign raw = {sync_mode, rx_din, rx_fsync, rx_bclk, tx_fsync, tx_bclk};

    pcm_pin_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (raw),
        .level (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl[NEDGE-1:0];
    end

    assign tx_bclk_rise = lvl[I_TXB] & ~prev_q[I_TXB];
    assign tx_bclk_fall = ~lvl[I_TXB] & prev_q[I_TXB];
    assign tx_fs_rise   = lvl[I_TXF] & ~prev_q[I_TXF];
    assign tx_fs_fall   = ~lvl[I_TXF] & prev_q[I_TXF];
    assign rx_bclk_fall = ~lvl[I_RXB] & prev_q[I_RXB];
    assign rx_fs_rise   = lvl[I_RXF] & ~prev_q[I_RXF];
    assign rx_clk_fall  = lvl[I_SM] ? tx_bclk_fall : rx_bclk_fall;

    pcm_fs_detect #(.LONG_MIN(LONG_MIN)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_level  (lvl[I_TXF]),
        .fs_rise   (tx_fs_rise),
        .fs_fall   (tx_fs_fall),
        .bclk_fall (tx_bclk_fall),
        .mode_long (frame_long)
    );

    pcm_tx_fsm #(.W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_long  (frame_long),
        .bclk_level (lvl[I_TXB]),
        .bclk_rise  (tx_bclk_rise),
        .bclk_fall  (tx_bclk_fall),
        .fs_level   (lvl[I_TXF]),
        .fs_rise    (tx_fs_rise),
        .load       (tx_load),
        .word       (tx_word),
        .dout       (tx_dout),
        .oe         (tx_oe)
    );

    pcm_rx_fsm #(.W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_long (frame_long),
        .bclk_fall (rx_clk_fall),
        .fs_level  (lvl[I_RXF]),
        .fs_rise   (rx_fs_rise),
        .din       (lvl[I_DIN]),
        .word      (rx_word),
        .valid     (rx_valid)
    );
endmodule

// File: rtl/pcm_serial_port_checker.sv
module pcm_serial_port_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_oe,
    input logic rx_valid,
    input logic frame_long,
    input logic ev_tx_rise,
    input logic ev_tx_fall,
    input logic ev_fs_rise,
    input logic ev_fs_fall,
    input logic ev_rx_fall
);
    // R2 / R7: driver turns on only after a clock rise or a sync rise
    assert_oe_rises_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> $past(ev_tx_rise || ev_fs_rise));

    // R3 / R8: driver turns off only after a clock fall or a sync fall
    assert_oe_falls_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_oe) |-> $past(ev_tx_fall || ev_fs_fall));

    // R4: a published word always follows a receive clock fall
    assert_valid_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(ev_rx_fall));

    // R5: mode changes only at the end of a transmit sync pulse
    assert_mode_on_fs_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_long != $past(frame_long)) |-> $past(ev_fs_fall));

    // R12: strobe lasts a single cycle
    assert_valid_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind pcm_serial_port pcm_serial_port_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_oe      (tx_oe),
    .rx_valid   (rx_valid),
    .frame_long (frame_long),
    .ev_tx_rise (tx_bclk_rise),
    .ev_tx_fall (tx_bclk_fall),
    .ev_fs_rise (tx_fs_rise),
    .ev_fs_fall (tx_fs_fall),
    .ev_rx_fall (rx_clk_fall)
);

// File: tb/pcm_serial_port_test.sv
`timescale 1ns/1ps
module pcm_serial_port_test;
    localparam int H    = 8;
    localparam int P    = 2 * H;
    localparam int MAXT = 16 * P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_mode = 1'b0;
    logic tx_bclk = 1'b0, tx_fsync = 1'b0, tx_load = 1'b0;
    logic [7:0] tx_word = '0;
    logic rx_bclk = 1'b0, rx_fsync = 1'b0, rx_din = 1'b0;
    logic tx_dout, tx_oe, rx_valid, frame_long;
    logic [7:0] rx_word;

    always #2.5 clk = ~clk;

    pcm_serial_port uut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
        .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .tx_word(tx_word), .tx_load(tx_load),
        .tx_dout(tx_dout), .tx_oe(tx_oe),
        .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_din(rx_din),
        .rx_word(rx_word), .rx_valid(rx_valid), .frame_long(frame_long)
    );

    int vec = 0, bad = 0;
    bit finished = 0;
    logic oe_log [MAXT];
    logic dout_log [MAXT];

    // receive monitor, away from the active edge
    int rx_cnt = 0, run = 0, max_run = 0;
    logic [7:0] rx_last = '0;
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt++;
            rx_last = rx_word;
            run++;
        end else begin
            if (run > max_run) max_run = run;
            run = 0;
        end
    end

    function automatic logic exp_bit(logic [7:0] w, int k);
        return w[7-k];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(int nper, int txs, int txl, int rxs, int rxl,
                             logic [7:0] rxd, int rxfirst, bit rxclk_on,
                             int load_at, logic [7:0] load_word);
        for (int t = 0; t < nper * P; t++) begin
            int p, idx;
            p   = t / P;
            idx = p - rxfirst;
            tx_bclk  = (t % P) < H;
            rx_bclk  = rxclk_on ? ((t % P) < H) : 1'b0;
            tx_fsync = (t >= txs) && (t < txs + txl);
            rx_fsync = (t >= rxs) && (t < rxs + rxl);
            rx_din   = (idx >= 0 && idx < 8) ? rxd[7-idx] : 1'b0;
            tx_load  = (t == load_at);
            if (t == load_at) tx_word = load_word;
            @(posedge clk); #1;
            oe_log[t]   = tx_oe;
            dout_log[t] = tx_dout;
        end
        tx_load = 1'b0;
    endtask

    // bits in periods first_p..first_p+7, sampled late in the high half
    task automatic check_tx(int first_p, logic [7:0] w, string req, bit check_off);
        if (first_p > 0)
            chk(oe_log[first_p*P - 1] == 1'b0, req, oe_log[first_p*P - 1], 0);
        for (int k = 0; k < 8; k++) begin
            int t;
            t = (first_p + k) * P + H - 1;
            chk(oe_log[t] == 1'b1 && dout_log[t] == exp_bit(w, k), req,
                {oe_log[t], dout_log[t]}, {1'b1, exp_bit(w, k)});
        end
        if (check_off)
            chk(oe_log[(first_p + 7) * P + P - 1] == 1'b0, req,
                oe_log[(first_p + 7) * P + P - 1], 0);
    endtask

    task automatic check_rx(int c0, logic [7:0] d, string req);
        chk(rx_cnt == c0 + 1, req, rx_cnt, c0 + 1);
        chk(rx_last == d, req, rx_last, d);
        chk(max_run == 1, "R12 strobe width", max_run, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            vec++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, b, d;
        int c0, off;
        void'($urandom(32'd20240611));
        repeat (10) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        // R1
        chk(tx_oe == 0 && tx_dout == 0, "R1 tx idle", {tx_oe, tx_dout}, 0);
        chk(rx_valid == 0 && rx_cnt == 0, "R1 rx idle", rx_cnt, 0);
        chk(frame_long == 0, "R1 short mode", frame_long, 0);

        // R2 R3 R4: random short frames
        for (int i = 0; i < 4; i++) begin
            a = 8'($urandom); d = 8'($urandom);
            c0 = rx_cnt; max_run = 0;
            run_frame(10, 0, P, 0, (i == 3) ? 3 * P : P, d, 1, 1'b1, 0, a);
            check_tx(1, a, "R2 R3 short tx", 1'b1);
            check_rx(c0, d, "R4 short rx");
            if (i == 3) chk(frame_long == 0, "R5 rx width ignored", frame_long, 0);
        end

        // R11: load mid-frame goes to the next frame
        a = 8'hA5; b = 8'h3C;
        run_frame(10, 0, P, 0, 0, 8'h00, 1, 1'b1, 0, a);
        run_frame(10, 0, P, 0, 0, 8'h00, 1, 1'b1, 5 * P, b);
        check_tx(1, a, "R11 frame keeps start word", 1'b1);
        run_frame(10, 0, P, 0, 0, 8'h00, 1, 1'b1, -1, 8'h00);
        check_tx(1, b, "R11 next frame new word", 1'b1);

        // R10: receive on transmit clock, rx_bclk idle
        sync_mode = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        d = 8'($urandom); c0 = rx_cnt; max_run = 0;
        run_frame(10, 0, P, 0, P, d, 1, 1'b0, -1, 8'h00);
        check_rx(c0, d, "R10 sync mode capture");
        sync_mode = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        c0 = rx_cnt;
        run_frame(10, 0, P, 0, P, 8'hFF, 1, 1'b0, -1, 8'h00);
        chk(rx_cnt == c0, "R10 idle rx_bclk no capture", rx_cnt, c0);

        // R6 in short mode: 2-period sync keeps short
        a = 8'($urandom);
        run_frame(10, 0, 2 * P, 0, 0, 8'h00, 1, 1'b1, 0, a);
        check_tx(1, a, "R6 short kept tx", 1'b1);
        chk(frame_long == 0, "R6 short kept", frame_long, 0);

        // R5: training pulse of 3 periods selects long
        run_frame(10, 0, 3 * P, 0, 0, 8'h00, 1, 1'b1, -1, 8'h00);
        chk(frame_long == 1, "R5 long detected", frame_long, 1);

        // R7 R8 R9: random long frames, sync and clock rising together
        for (int i = 0; i < 3; i++) begin
            a = 8'($urandom); d = 8'($urandom);
            c0 = rx_cnt; max_run = 0;
            run_frame(10, 0, 3 * P, 0, 3 * P, d, 0, 1'b1, 0, a);
            check_tx(0, a, "R7 R8 long tx", 1'b1);
            check_rx(c0, d, "R9 long rx");
        end

        // R7: sync rises while clock already high
        off = 1 + int'($urandom % 3);
        a = 8'($urandom);
        run_frame(10, off, 3 * P, 0, 0, 8'h00, 0, 1'b1, 0, a);
        chk(oe_log[off - 1] == 0, "R7 not before sync", oe_log[off - 1], 0);
        check_tx(0, a, "R7 sync later than clock", 1'b1);

        // R7: sync rises while clock low, waits for the rise
        a = 8'($urandom);
        run_frame(11, H + 2, 3 * P, 0, 0, 8'h00, 0, 1'b1, 0, a);
        check_tx(1, a, "R7 clock later than sync", 1'b1);

        // R8: sync held past the eighth bit
        a = 8'($urandom) | 8'h01;
        run_frame(12, 0, 10 * P, 0, 0, 8'h00, 0, 1'b1, 0, a);
        check_tx(0, a, "R8 long held tx", 1'b0);
        chk(oe_log[8 * P + P - 1] == 1 && dout_log[8 * P + P - 1] == a[0],
            "R8 held while sync high", {oe_log[8 * P + P - 1], dout_log[8 * P + P - 1]}, {1'b1, a[0]});
        chk(oe_log[10 * P + H - 1] == 0, "R8 off after sync low", oe_log[10 * P + H - 1], 0);

        // R6 in long mode
        a = 8'($urandom);
        run_frame(10, 0, 2 * P, 0, 0, 8'h00, 0, 1'b1, 0, a);
        check_tx(0, a, "R6 long kept tx", 1'b1);
        chk(frame_long == 1, "R6 long kept", frame_long, 1);

        // R5: one-period pulse returns to short
        run_frame(10, 0, P, 0, 0, 8'h00, 0, 1'b1, -1, 8'h00);
        chk(frame_long == 0, "R5 back to short", frame_long, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule